// File: doc/BRIEF.md
# Scan Delay Test Launch Controller

This block sequences a scan chain and the system clock for one path-delay test. It runs from a fast free-running clock. It produces a one-cycle system clock enable pulse for each edge the scan flip-flops should see, and a scan-enable level that puts those flip-flops in scan mode (high) or normal mode (low). The first vector (V1) is shifted in at a slow edge spacing. A launch edge then creates the second vector (V2). The result is captured exactly one rated interval after the launch edge and is then shifted out at slow spacing. While the result shifts out, the next V1 can shift in over the same edges.

Two launch methods are supported. With launch-by-shift, V2 is one extra scan shift of V1, and scan-enable falls only after the launch edge, inside the rated window. With launch-by-capture, scan-enable is already low for the whole launch interval, and V2 comes from one functional capture of V1. Only the launch-to-capture gap uses the rated spacing. Every other gap uses the slow spacing. The scan chain, pattern storage and response analysis lie outside the block.

Top module: `dly_launch_ctrl`

## Requirements
- R1: After reset the block is idle: busy, done, sys_clk_en, shift_ph and capt_ph are low and scan_en is high.
- R2: A start seen while idle latches mode, chain_len, slow_ticks and rated_ticks and sets busy from the next cycle. A zero chain_len, slow_ticks or rated_ticks is used as 1.
- R3: Load phase. Counting the accepting edge as cycle 0, the load phase gives chain_len enable pulses at cycles S, 2S, … L·S (S = slow spacing, L = chain length). Each of these pulses has scan_en high and shift_ph high.
- R4: Launch with mode = 0 (shift). The launch pulse comes at cycle (L+1)·S with scan_en still high. scan_en is low from the following cycle.
- R5: Launch with mode = 1 (capture). scan_en is low from the cycle after the last load pulse through the launch pulse, so the launch pulse has scan_en low.
- R6: The capture pulse comes exactly rated_ticks cycles after the launch pulse, with scan_en low. capt_ph is high from the cycle after the launch pulse up to and including the capture pulse, and is low at every other pulse.
- R7: Unload phase. L further pulses follow, spaced S apart with the first one S after the capture pulse. Each has scan_en high and shift_ph high.
- R8: busy stays high through the cycle of the last unload pulse, at cycle (2L+1)·S+R. done is high for exactly the next cycle, when busy is low.
- R9: While busy, start and any change of mode, chain_len, slow_ticks or rated_ticks have no effect on the pulse timing or levels.
- R10: No enable pulse appears while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one test (taken only while idle) |
| mode | input | 1 | 0: launch by one extra shift, 1: launch by functional capture |
| chain_len | input | LEN_W | Number of scan shifts per load or unload |
| slow_ticks | input | CNT_W | Clock cycles between slow edges |
| rated_ticks | input | CNT_W | Clock cycles from launch edge to capture edge |
| scan_en | output | 1 | Test control: high selects scan shift, low selects normal capture |
| sys_clk_en | output | 1 | One-cycle enable for a system clock edge |
| shift_ph | output | 1 | High during load and unload shifting |
| capt_ph | output | 1 | High during the rated launch-to-capture window |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse after the last unload edge |

## Verification
The same sequence runs with both launch methods and otherwise equal settings. Any difference in the scan_en level at the launch pulse, and in the cycle just before it, therefore isolates the two launch methods. Runs with a rated spacing shorter than, equal to one, and longer than the slow spacing show whether the capture timer really switches its period only for the one rated gap. Zero-valued settings show the floor-at-one rule. Runs that pulse start and alter every setting mid-test show whether the configuration is latched.

// File: rtl/dly_launch_pkg.sv
package dly_launch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LAUNCH,
    ST_CAPTURE,
    ST_UNLOAD
  } phase_t;

  typedef enum logic {
    LAUNCH_SHIFT = 1'b0,
    LAUNCH_FUNC  = 1'b1
  } launch_mode_t;

  // Settings of zero are raised to one so every interval lasts a cycle.
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Test-control level for a phase: only the capture window and a
  // functional launch interval run in normal mode.
  function automatic logic scan_level(input phase_t st, input launch_mode_t m);
    case (st)
      ST_LAUNCH:  return (m == LAUNCH_SHIFT);
      ST_CAPTURE: return 1'b0;
      default:    return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/dly_tick_timer.sv
module dly_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: each edge begins a fresh interval
  a_r3_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

  // R6: the count never passes the active period, so the rated gap is exact
  a_r6_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < period));

endmodule

// File: rtl/dly_edge_counter.sv
module dly_edge_counter #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] limit,
  output logic             last
);

  logic [LEN_W-1:0] cnt;

  assign last = (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  // R7: the count wraps after the last shift so unload starts at zero
  a_r7_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !clear) |=> (cnt == '0));

endmodule

// File: rtl/dly_launch_fsm.sv
module dly_launch_fsm
  import dly_launch_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [LEN_W-1:0] chain_len,
  input  logic [CNT_W-1:0] slow_ticks,
  input  logic [CNT_W-1:0] rated_ticks,
  input  logic             tick,
  input  logic             bits_last,
  output logic             accept,
  output logic             timer_run,
  output logic [CNT_W-1:0] period,
  output logic             bit_step,
  output logic [LEN_W-1:0] len_q,
  output logic             scan_en,
  output logic             shift_ph,
  output logic             capt_ph,
  output logic             busy,
  output logic             done
);

  phase_t           st;
  launch_mode_t     mode_q;
  logic [CNT_W-1:0] slow_q;
  logic [CNT_W-1:0] rated_q;
  logic             launch_edge;
  logic             capture_edge;
  logic             load_end;
  logic             unload_end;

  assign accept       = (st == ST_IDLE) && start;
  assign timer_run    = (st != ST_IDLE);
  assign period       = (st == ST_CAPTURE) ? rated_q : slow_q;
  assign shift_ph     = (st == ST_LOAD) || (st == ST_UNLOAD);
  assign capt_ph      = (st == ST_CAPTURE);
  assign busy         = (st != ST_IDLE);
  assign bit_step     = tick && shift_ph;
  assign launch_edge  = tick && (st == ST_LAUNCH);
  assign capture_edge = tick && (st == ST_CAPTURE);
  assign load_end     = tick && bits_last && (st == ST_LOAD);
  assign unload_end   = tick && bits_last && (st == ST_UNLOAD);
  assign scan_en      = scan_level(st, mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      mode_q  <= LAUNCH_SHIFT;
      len_q   <= LEN_W'(1);
      slow_q  <= CNT_W'(1);
      rated_q <= CNT_W'(1);
      done    <= 1'b0;
    end else begin
      done <= unload_end;
      if (accept) begin
        st      <= ST_LOAD;
        mode_q  <= launch_mode_t'(mode);
        len_q   <= LEN_W'(at_least_one(32'(chain_len)));
        slow_q  <= CNT_W'(at_least_one(32'(slow_ticks)));
        rated_q <= CNT_W'(at_least_one(32'(rated_ticks)));
      end else begin
        case (st)
          ST_LOAD:    if (load_end)     st <= ST_LAUNCH;
          ST_LAUNCH:  if (launch_edge)  st <= ST_CAPTURE;
          ST_CAPTURE: if (capture_edge) st <= ST_UNLOAD;
          ST_UNLOAD:  if (unload_end)   st <= ST_IDLE;
          default:    st <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: shift launch leaves scan mode right after the launch edge
  a_r4_shift_launch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_edge && mode_q == LAUNCH_SHIFT) |=> !scan_en);

  // R5: functional launch happens in normal mode
  a_r5_func_launch_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_edge && mode_q == LAUNCH_FUNC) |-> !scan_en);

  // R6: the rated window opens right after launch and captures in normal mode
  a_r6_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    launch_edge |=> capt_ph);
  a_r6_capture_normal: assert property (@(posedge clk) disable iff (!rst_n)
    capture_edge |-> !scan_en);

  // R8: done follows the busy interval by one cycle
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9: busy only rises on a start, and settings hold while busy
  a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(len_q) &&
                               $stable(slow_q) && $stable(rated_q)));

endmodule

// File: rtl/dly_launch_ctrl.sv
module dly_launch_ctrl #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [LEN_W-1:0] chain_len,
  input  logic [CNT_W-1:0] slow_ticks,
  input  logic [CNT_W-1:0] rated_ticks,
  output logic             scan_en,
  output logic             sys_clk_en,
  output logic             shift_ph,
  output logic             capt_ph,
  output logic             busy,
  output logic             done
);

  logic             accept;
  logic             timer_run;
  logic [CNT_W-1:0] period;
  logic             tick;
  logic             bit_step;
  logic             bits_last;
  logic [LEN_W-1:0] len_q;

  dly_launch_fsm #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .chain_len  (chain_len),
    .slow_ticks (slow_ticks),
    .rated_ticks(rated_ticks),
    .tick       (tick),
    .bits_last  (bits_last),
    .accept     (accept),
    .timer_run  (timer_run),
    .period     (period),
    .bit_step   (bit_step),
    .len_q      (len_q),
    .scan_en    (scan_en),
    .shift_ph   (shift_ph),
    .capt_ph    (capt_ph),
    .busy       (busy),
    .done       (done)
  );

  dly_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .restart(accept),
    .period (period),
    .tick   (tick)
  );

  dly_edge_counter #(.LEN_W(LEN_W)) u_bits (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(accept),
    .step (bit_step),
    .limit(len_q),
    .last (bits_last)
  );

  assign sys_clk_en = tick;

  // R10: edges only while a test runs
  a_r10_no_edge_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en |-> busy);

endmodule

// File: tb/dly_launch_ctrl_bench.sv
module dly_launch_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int LEN_W = 10;
  localparam int MAX_EDGES = 64;

  typedef struct packed {
    logic       mode;
    logic [7:0] len;
    logic [7:0] slow;
    logic [7:0] rated;
    logic       disturb;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd3, 8'd4, 8'd2, 1'b0},
    '{1'b1, 8'd3, 8'd4, 8'd2, 1'b0},
    '{1'b0, 8'd1, 8'd3, 8'd1, 1'b0},
    '{1'b1, 8'd0, 8'd0, 8'd0, 1'b0},
    '{1'b0, 8'd4, 8'd2, 8'd5, 1'b1},
    '{1'b1, 8'd2, 8'd5, 8'd3, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mode = 1'b0;
  logic [LEN_W-1:0] chain_len = '0;
  logic [CNT_W-1:0] slow_ticks = '0;
  logic [CNT_W-1:0] rated_ticks = '0;
  logic             scan_en, sys_clk_en, shift_ph, capt_ph, busy, done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_launch_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_dly_launch_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .chain_len(chain_len), .slow_ticks(slow_ticks), .rated_ticks(rated_ticks),
    .scan_en(scan_en), .sys_clk_en(sys_clk_en), .shift_ph(shift_ph),
    .capt_ph(capt_ph), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int floor1(input int x);
    return (x < 1) ? 1 : x;
  endfunction

  task automatic run_vec(input vec_t v);
    int l, s, r, tot, nexp, nseen, launch_t, busy_err, done_err;
    int et [MAX_EDGES];
    bit ese [MAX_EDGES];
    bit esh [MAX_EDGES];
    bit ecp [MAX_EDGES];
    l = floor1(int'(v.len));
    s = floor1(int'(v.slow));
    r = floor1(int'(v.rated));
    launch_t = (l + 1) * s;
    tot = (2 * l + 1) * s + r;
    nexp = 2 * l + 2;
    nseen = 0; busy_err = 0; done_err = 0;
    mode = v.mode;
    chain_len = LEN_W'(v.len);
    slow_ticks = v.slow;
    rated_ticks = v.rated;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= tot + 6; c++) begin
      if (sys_clk_en) begin
        if (nseen < MAX_EDGES) begin
          et[nseen] = c; ese[nseen] = scan_en;
          esh[nseen] = shift_ph; ecp[nseen] = capt_ph;
        end
        nseen++;
      end
      if (busy != (c <= tot)) busy_err++;
      if (done != (c == tot + 1)) done_err++;
      if (c == launch_t + 1) begin
        chk(!scan_en, "R4 scan_en after launch", int'(scan_en), 0);
        chk(capt_ph, "R6 capt_ph after launch", int'(capt_ph), 1);
      end
      if (v.mode && c == l * s + 1)
        chk(!scan_en, "R5 scan_en at launch interval start", int'(scan_en), 0);
      if (c > tot + 1)
        chk(!sys_clk_en, "R10 no edge once idle", int'(sys_clk_en), 0);
      if (v.disturb && c == 3) begin
        start = 1'b1; mode = ~v.mode;
        chain_len = LEN_W'(7); slow_ticks = 8'd1; rated_ticks = 8'd1;
      end
      if (v.disturb && c == 4) start = 1'b0;
      @(negedge clk);
    end
    chk(nseen == nexp, v.disturb ? "R9 edge count under disturbance" : "R3 R7 edge count",
        nseen, nexp);
    chk(busy_err == 0, "R8 busy span", busy_err, 0);
    chk(done_err == 0, "R8 done pulse cycle", done_err, 0);
    for (int i = 0; i < nexp && i < nseen; i++) begin
      int xt;
      bit xse, xsh, xcp;
      if (i < l) begin
        xt = (i + 1) * s; xse = 1; xsh = 1; xcp = 0;
      end else if (i == l) begin
        xt = launch_t; xse = !v.mode; xsh = 0; xcp = 0;
      end else if (i == l + 1) begin
        xt = launch_t + r; xse = 0; xsh = 0; xcp = 1;
      end else begin
        xt = launch_t + r + (i - l - 1) * s; xse = 1; xsh = 1; xcp = 0;
      end
      chk(et[i] == xt, (i < l) ? "R3 load edge cycle" : (i == l) ? "R4 R5 launch edge cycle" :
          (i == l + 1) ? "R6 capture edge cycle" : "R7 unload edge cycle", et[i], xt);
      chk(ese[i] == xse, (i == l) ? "R4 R5 scan_en at launch" : "R3 R6 R7 scan_en at edge",
          int'(ese[i]), int'(xse));
      chk(esh[i] == xsh, "R3 R7 shift_ph at edge", int'(esh[i]), int'(xsh));
      chk(ecp[i] == xcp, "R6 capt_ph at edge", int'(ecp[i]), int'(xcp));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(!done, "R1 done after reset", int'(done), 0);
    chk(scan_en, "R1 scan_en after reset", int'(scan_en), 1);
    chk(!sys_clk_en, "R1 sys_clk_en after reset", int'(sys_clk_en), 0);
    chk(!shift_ph && !capt_ph, "R1 phase flags after reset",
        int'({shift_ph, capt_ph}), 0);
    // R10 idle without start
    for (int k = 0; k < 5; k++) begin
      chk(!sys_clk_en && !busy, "R10 idle quiet", int'({sys_clk_en, busy}), 0);
      @(negedge clk);
    end
    // Table walk: R2 through R9 (entry 3 covers the zero-as-one rule of R2)
    for (int n = 0; n < NVEC; n++) begin
      run_vec(VECS[n]);
      repeat (2) @(negedge clk);
    end
    // R2: busy rises the cycle after start
    mode = 1'b0; chain_len = LEN_W'(2); slow_ticks = 8'd3; rated_ticks = 8'd2;
    start = 1'b1;
    chk(!busy, "R2 not busy before start edge", int'(busy), 0);
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2 busy after start edge", int'(busy), 1);
    repeat (40) @(negedge clk);
    chk(!busy, "R8 idle after short run", int'(busy), 0);
    // R1 reset in mid-run returns to idle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && scan_en && !sys_clk_en, "R1 reset mid-run",
        int'({busy, scan_en, sys_clk_en}), 2);
    summary();
  end

endmodule